// File: doc/BRIEF.md
# I2C Command/Data Master

This block is an I2C bus master that runs one complete transaction each time it sees a start pulse. A transaction always has the same shape: a START condition, the 7-bit target address with a direction bit, a command/address phase of zero to four bytes, a data phase of zero to four bytes, and a STOP condition. The command/address bytes and the write data bytes are taken from two 32-bit words. Two small count fields set the length of each phase.

In write mode every byte after the address comes from the master. In read mode the command/address bytes are still sent by the master. The data-phase bytes are then driven by the target and gathered into a 32-bit read word. The bus pins are open-drain: the block only ever pulls SDA or SCL low through output enables and reads SDA back. SCL is derived from a fixed base tick, which a system-clock divider parameter produces, divided by an 8-bit prescale value. Status outputs report busy, a one-cycle done pulse and a sticky no-acknowledge flag.

Top module: `i2c_phase_master`

## Requirements
- R1: One SCL period lasts 4*TICK_DIV*(P+1) system clocks, where P is the prescale input and a value of 0 is treated as 1.
- R2: A transaction opens with a START (SDA falls while SCL is high) and closes with a STOP (SDA rises while SCL is high). The first byte is {address[6:0], rw}, with rw=1 for read and rw=0 for write. Every byte is sent MSB first, and each byte is followed by an acknowledge slot.
- R3: After the address, the master sends N command bytes, with N taken from cmdCount. Byte i comes from cmdWord[8i+7:8i], in ascending i. N=0 skips the phase, and counts 5 to 7 act as 4.
- R4: In write mode, after the command bytes, the master sends M data bytes, with M taken from dataCount and clamped in the same way. Byte i comes from dataWord[8i+7:8i].
- R5: In read mode, the M data bytes are driven by the target and stored MSB first into rdData[8i+7:8i]. rdData is cleared when a transaction is accepted, so byte lanes that are not read stay 0.
- R6: In read mode, the master drives ACK (SDA low) after every data byte except the last one. It leaves SDA high (NACK) after the last data byte.
- R7: If the target leaves SDA high in the acknowledge slot of the address, a command byte or a write data byte, then the nack output is set, the remaining bytes are skipped, a STOP is sent and done pulses. nack stays set until the next accepted start clears it.
- R8: Inside a transaction, SDA changes only while SCL is low, except for START and STOP. Outside a transaction, both output enables are 0.
- R9: busy is high from the cycle after a start is accepted until the transaction ends. done is high for exactly one cycle, in the cycle where busy falls.
- R10: A start pulse while busy is ignored. Address, words, counts and direction are sampled when a start is accepted, so later changes to them do not affect the running transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begins a transaction when idle |
| readMode | input | 1 | 1 = data phase read from target, 0 = written |
| slaveAddr | input | 7 | 7-bit target address |
| cmdWord | input | 32 | Command/address bytes, byte 0 in [7:0] |
| cmdCount | input | 3 | Number of command/address bytes (0 to 4) |
| dataWord | input | 32 | Write data bytes, byte 0 in [7:0] |
| dataCount | input | 3 | Number of data bytes (0 to 4) |
| prescale | input | 8 | SCL divider value |
| sdaIn | input | 1 | Sampled SDA bus level |
| sdaOe | output | 1 | Pull SDA low when 1 |
| sclOe | output | 1 | Pull SCL low when 1 |
| rdData | output | 32 | Bytes captured in read mode |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at transaction end |
| nack | output | 1 | Sticky: target withheld an acknowledge |

## Verification
The hardest situation to reach from the ports is a target that acknowledges some bytes and then refuses one in the middle of the command phase. The master must stop cleanly on that exact byte, without sending the rest of the frame. The bench uses a scripted bus target that is told in advance which byte index to refuse. It compares every byte it receives against the expected stream queued by the driver, so any byte sent after the refusal shows up as an extra or mismatched item. Read transactions use the same target to supply data and to record the master's acknowledge level after each data byte.

// File: rtl/i2c_phase_pkg.sv
package i2c_phase_pkg;
  localparam int MAX_BYTES = 4;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = MAX_BYTES * BYTE_W;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);
  localparam int IDX_W     = $clog2(MAX_BYTES);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_BITS, ST_ACK, ST_STOP
  } state_t;

  typedef enum logic [1:0] {
    SEG_ADDR, SEG_CMD, SEG_DATA
  } seg_t;

  typedef struct packed {
    logic             capture;
    logic             load;
    seg_t             loadSeg;
    logic [IDX_W-1:0] loadIdx;
    logic             shift;
    logic             commit;
    logic [IDX_W-1:0] commitIdx;
  } dp_strobe_t;
endpackage

// File: rtl/i2c_phase_tick.sv
module i2c_phase_tick #(
  parameter int TICK_DIV = 128,
  parameter int PRE_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [PRE_W-1:0] prescale,
  output logic             qTick
);
  localparam int BW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [BW-1:0]    baseCnt;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] effPre;
  logic             baseTick;

  assign effPre   = (prescale == '0) ? PRE_W'(1) : prescale;
  assign baseTick = run && (baseCnt == BW'(TICK_DIV - 1));
  assign qTick    = baseTick && (preCnt >= effPre);

  always_ff @(posedge clk) begin
    if (!rstN || !run) begin
      baseCnt <= '0;
      preCnt  <= '0;
    end else begin
      if (baseTick) baseCnt <= '0;
      else          baseCnt <= baseCnt + BW'(1);
      if (qTick)         preCnt <= '0;
      else if (baseTick) preCnt <= preCnt + PRE_W'(1);
    end
  end

  // R1: quarter ticks are never back to back (prescale floor of 1)
  a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rstN)
    qTick |=> !qTick);
endmodule

// File: rtl/i2c_phase_dp.sv
module i2c_phase_dp
  import i2c_phase_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        ctl,
  input  logic [6:0]        slaveAddr,
  input  logic              readMode,
  input  logic [WORD_W-1:0] cmdWord,
  input  logic [WORD_W-1:0] dataWord,
  input  logic              sdaIn,
  output logic              txBit,
  output logic [WORD_W-1:0] rdData
);
  logic [BYTE_W-1:0] addrByte;
  logic [WORD_W-1:0] cmdReg;
  logic [WORD_W-1:0] dataReg;
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] selByte;

  always_comb begin
    unique case (ctl.loadSeg)
      SEG_ADDR: selByte = addrByte;
      SEG_CMD:  selByte = cmdReg[ctl.loadIdx*BYTE_W +: BYTE_W];
      default:  selByte = dataReg[ctl.loadIdx*BYTE_W +: BYTE_W];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrByte <= '0;
      cmdReg   <= '0;
      dataReg  <= '0;
      shiftReg <= '0;
    end else begin
      if (ctl.capture) begin
        addrByte <= {slaveAddr, readMode};
        cmdReg   <= cmdWord;
        dataReg  <= dataWord;
      end
      if (ctl.load)       shiftReg <= selByte;
      else if (ctl.shift) shiftReg <= {shiftReg[BYTE_W-2:0], sdaIn};
    end
  end

  assign txBit = shiftReg[BYTE_W-1];

  for (genvar g = 0; g < MAX_BYTES; g++) begin : gLane
    logic [BYTE_W-1:0] lane;
    always_ff @(posedge clk) begin
      if (!rstN || ctl.capture)
        lane <= '0;
      else if (ctl.commit && ctl.commitIdx == IDX_W'(g))
        lane <= shiftReg;
    end
    assign rdData[g*BYTE_W +: BYTE_W] = lane;
  end

  // R5: an accepted start leaves the read word empty
  a_r5_clear_on_start: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> rdData == '0);
  // R5: a byte is never stored in the same cycle a new one is loaded
  a_r5_commit_excl: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |-> !ctl.load && !ctl.shift);
endmodule

// File: rtl/i2c_phase_ctrl.sv
module i2c_phase_ctrl
  import i2c_phase_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             qTick,
  input  logic             startPulse,
  input  logic             readMode,
  input  logic [CNT_W-1:0] cmdCount,
  input  logic [CNT_W-1:0] dataCount,
  input  logic             sdaIn,
  input  logic             txBit,
  output logic             run,
  output dp_strobe_t       ctl,
  output logic             sclOe,
  output logic             sdaOe,
  output logic             busy,
  output logic             done,
  output logic             nack
);
  state_t           state, stateNx;
  seg_t             seg, segNx;
  logic [1:0]       qPh;
  logic [2:0]       bitCnt;
  logic [IDX_W-1:0] idx, idxNx;
  logic [CNT_W-1:0] cmdN, dataN;
  logic             rdMode, hasNext, rxBits, accept;
  logic             sdaHold, sdaHoldNx, ackNack;
  logic             sclLvl, sdaLvl, newRx;

  function automatic logic [CNT_W-1:0] clampCnt(input logic [CNT_W-1:0] c);
    return (c > CNT_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : c;
  endfunction

  assign accept = startPulse && (state == ST_IDLE);
  assign busy   = (state != ST_IDLE);
  assign run    = busy;
  assign rxBits = rdMode && (seg == SEG_DATA);

  // which byte follows the current one
  always_comb begin
    hasNext = 1'b0;
    segNx   = SEG_DATA;
    idxNx   = '0;
    unique case (seg)
      SEG_ADDR: begin
        if (cmdN != '0) begin
          hasNext = 1'b1;
          segNx   = SEG_CMD;
        end else if (dataN != '0) begin
          hasNext = 1'b1;
        end
      end
      SEG_CMD: begin
        if ((CNT_W'(idx) + CNT_W'(1)) < cmdN) begin
          hasNext = 1'b1;
          segNx   = SEG_CMD;
          idxNx   = idx + IDX_W'(1);
        end else if (dataN != '0) begin
          hasNext = 1'b1;
        end
      end
      default: begin
        if ((CNT_W'(idx) + CNT_W'(1)) < dataN) begin
          hasNext = 1'b1;
          idxNx   = idx + IDX_W'(1);
        end
      end
    endcase
  end

  // slot sequencing, evaluated at the end of quarter 3
  always_comb begin
    stateNx = state;
    unique case (state)
      ST_START: stateNx = ST_BITS;
      ST_BITS:  stateNx = (bitCnt == 3'd0) ? ST_ACK : ST_BITS;
      ST_ACK:   stateNx = (ackNack || !hasNext) ? ST_STOP : ST_BITS;
      ST_STOP:  stateNx = ST_IDLE;
      default:  stateNx = state;
    endcase
  end

  // SDA level held for the whole of the next slot
  always_comb begin
    newRx     = (state == ST_ACK) ? (rdMode && segNx == SEG_DATA) : rxBits;
    sdaHoldNx = 1'b1;
    if (stateNx == ST_BITS)     sdaHoldNx = newRx ? 1'b1 : txBit;
    else if (stateNx == ST_ACK) sdaHoldNx = rxBits ? !hasNext : 1'b1;
  end

  // bus levels for the current quarter
  always_comb begin
    sclLvl = 1'b1;
    sdaLvl = 1'b1;
    unique case (state)
      ST_START: begin
        sclLvl = (qPh != 2'd3);
        sdaLvl = (qPh < 2'd2);
      end
      ST_BITS, ST_ACK: begin
        sclLvl = (qPh == 2'd1) || (qPh == 2'd2);
        sdaLvl = sdaHold;
      end
      ST_STOP: begin
        sclLvl = (qPh != 2'd0);
        sdaLvl = (qPh >= 2'd2);
      end
      default: ;
    endcase
  end

  // strobes to the datapath
  always_comb begin
    ctl           = '0;
    ctl.capture   = accept;
    ctl.load      = qTick && (qPh == 2'd2) &&
                    ((state == ST_START) || (state == ST_ACK && hasNext));
    ctl.loadSeg   = (state == ST_START) ? SEG_ADDR : segNx;
    ctl.loadIdx   = (state == ST_START) ? '0 : idxNx;
    ctl.shift     = qTick && (qPh == 2'd2) && (state == ST_BITS);
    ctl.commit    = qTick && (qPh == 2'd1) && (state == ST_ACK) && rxBits;
    ctl.commitIdx = idx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      seg     <= SEG_ADDR;
      qPh     <= '0;
      bitCnt  <= '0;
      idx     <= '0;
      cmdN    <= '0;
      dataN   <= '0;
      rdMode  <= 1'b0;
      sdaHold <= 1'b1;
      ackNack <= 1'b0;
      nack    <= 1'b0;
      done    <= 1'b0;
      sclOe   <= 1'b0;
      sdaOe   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state   <= ST_START;
        qPh     <= '0;
        seg     <= SEG_ADDR;
        idx     <= '0;
        cmdN    <= clampCnt(cmdCount);
        dataN   <= clampCnt(dataCount);
        rdMode  <= readMode;
        nack    <= 1'b0;
        ackNack <= 1'b0;
      end else if (qTick) begin
        qPh <= qPh + 2'd1;
        if (qPh == 2'd2 && state == ST_ACK) begin
          if (rxBits) ackNack <= 1'b0;
          else begin
            ackNack <= sdaIn;
            if (sdaIn) nack <= 1'b1;
          end
        end
        if (qPh == 2'd3) begin
          state   <= stateNx;
          sdaHold <= sdaHoldNx;
          unique case (state)
            ST_START: bitCnt <= 3'd7;
            ST_BITS:  if (bitCnt != 3'd0) bitCnt <= bitCnt - 3'd1;
            ST_ACK: if (stateNx == ST_BITS) begin
              seg    <= segNx;
              idx    <= idxNx;
              bitCnt <= 3'd7;
            end
            ST_STOP:  done <= 1'b1;
            default: ;
          endcase
        end
      end
      sclOe <= !sclLvl;
      sdaOe <= !sdaLvl;
    end
  end

  // R8: with SCL high on both sides, SDA moves only in START or STOP
  a_r8_sda_edge: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) && !sclOe && !$past(sclOe)
      |-> ($past(state) == ST_START || $past(state) == ST_STOP));
  // R9: done only once the block is idle again
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R9: busy never falls without the done pulse
  a_r9_busy_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  // R8: the bus is released when a transaction ends
  a_r8_released: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !sdaOe && !sclOe);
  // R7: nack holds until a new start is accepted
  a_r7_nack_sticky: assert property (@(posedge clk) disable iff (!rstN)
    nack && !(startPulse && !busy) |=> nack);
endmodule

// File: rtl/i2c_phase_master.sv
module i2c_phase_master
  import i2c_phase_pkg::*;
#(
  parameter int TICK_DIV = 128,
  parameter int PRE_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              readMode,
  input  logic [6:0]        slaveAddr,
  input  logic [WORD_W-1:0] cmdWord,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [WORD_W-1:0] dataWord,
  input  logic [CNT_W-1:0]  dataCount,
  input  logic [PRE_W-1:0]  prescale,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic              sclOe,
  output logic [WORD_W-1:0] rdData,
  output logic              busy,
  output logic              done,
  output logic              nack
);
  logic       run, qTick, txBit;
  dp_strobe_t ctl;

  i2c_phase_tick #(.TICK_DIV(TICK_DIV), .PRE_W(PRE_W)) uTick (
    .clk(clk), .rstN(rstN), .run(run), .prescale(prescale), .qTick(qTick)
  );

  i2c_phase_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .qTick(qTick), .startPulse(startPulse),
    .readMode(readMode), .cmdCount(cmdCount), .dataCount(dataCount),
    .sdaIn(sdaIn), .txBit(txBit), .run(run), .ctl(ctl),
    .sclOe(sclOe), .sdaOe(sdaOe), .busy(busy), .done(done), .nack(nack)
  );

  i2c_phase_dp uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .slaveAddr(slaveAddr),
    .readMode(readMode), .cmdWord(cmdWord), .dataWord(dataWord),
    .sdaIn(sdaIn), .txBit(txBit), .rdData(rdData)
  );
endmodule

// File: tb/sim_i2c_phase_master.sv
`timescale 1ns/1ps
module sim_i2c_phase_master;
  localparam int TDIV = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        readMode = 1'b0;
  logic [6:0]  slaveAddr = '0;
  logic [31:0] cmdWord = '0;
  logic [2:0]  cmdCount = '0;
  logic [31:0] dataWord = '0;
  logic [2:0]  dataCount = '0;
  logic [7:0]  prescale = 8'd1;
  logic        sdaOe, sclOe, busy, done, nack;
  logic [31:0] rdData;
  logic        slvDrv = 1'b0;
  wire         sdaLine = !(sdaOe || slvDrv);
  wire         sclLine = !sclOe;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int lastRise = 0;
  int lastPeriod = 0;
  int starts = 0;
  int stops = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  int sWr, sTotal, sNack;
  logic [31:0] sRdWord;

  i2c_phase_master #(.TICK_DIV(TDIV)) u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .readMode(readMode),
    .slaveAddr(slaveAddr), .cmdWord(cmdWord), .cmdCount(cmdCount),
    .dataWord(dataWord), .dataCount(dataCount), .prescale(prescale),
    .sdaIn(sdaLine), .sdaOe(sdaOe), .sclOe(sclOe), .rdData(rdData),
    .busy(busy), .done(done), .nack(nack)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // period monitor (R1)
  initial forever begin
    @(posedge sclLine);
    lastPeriod = cyc - lastRise;
    lastRise   = cyc;
  end

  // START/STOP monitor (R2, R8)
  initial forever begin
    @(sdaLine);
    if (rstN && sclLine === 1'b1) begin
      if (sdaLine === 1'b0) starts++;
      else if (sdaLine === 1'b1) stops++;
    end
  end

  // scripted bus target and scoreboard monitor
  task automatic slaveRun();
    forever begin
      @(negedge sdaLine);
      if (sclLine) break;
    end
    for (int k = 0; k < sTotal; k++) begin
      if (k < sWr) begin
        logic [7:0] b;
        logic [7:0] e;
        string t;
        b = '0;
        for (int i = 0; i < 8; i++) begin
          @(posedge sclLine);
          b = {b[6:0], sdaLine};
        end
        @(negedge sclLine);
        slvDrv = (k != sNack);
        @(negedge sclLine);
        slvDrv = 1'b0;
        if (expQ.size() > 0) begin
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(b == e, t, "byte on bus", {24'd0, b}, {24'd0, e});
        end else
          chk(1'b0, "R2", "unexpected byte", {24'd0, b}, 32'd0);
        if (k == sNack) break;
      end else begin
        logic [7:0] d;
        logic       ackv;
        d = sRdWord[(k - sWr)*8 +: 8];
        for (int i = 7; i >= 0; i--) begin
          slvDrv = !d[i];
          @(posedge sclLine);
          @(negedge sclLine);
        end
        slvDrv = 1'b0;
        @(posedge sclLine);
        ackv = sdaLine;
        chk(ackv == (k == sTotal - 1), "R6", "master ack level",
            {31'd0, ackv}, {31'd0, (k == sTotal - 1)});
        @(negedge sclLine);
      end
    end
  endtask

  // driver: queues the expected frame, then runs one transaction
  task automatic runTxn(input bit rd, input logic [6:0] a,
                        input logic [31:0] cw, input int cn,
                        input logic [31:0] dw, input int dn,
                        input int pre, input int nackAt,
                        input logic [31:0] rdw, input bit poke);
    int cnE, dnE, k, t, pEff;
    logic [31:0] expRd;
    bit gotDone;
    cnE = (cn > 4) ? 4 : cn;
    dnE = (dn > 4) ? 4 : dn;
    pEff = (pre == 0) ? 1 : pre;
    sWr = 1 + cnE + (rd ? 0 : dnE);
    sTotal = 1 + cnE + dnE;
    sNack = nackAt;
    sRdWord = rdw;
    expQ.delete();
    tagQ.delete();
    k = 0;
    expQ.push_back({a, rd}); tagQ.push_back("R2");
    for (int i = 0; i < cnE; i++) begin
      k++;
      if (nackAt < 0 || k <= nackAt) begin
        expQ.push_back(cw[i*8 +: 8]); tagQ.push_back("R3");
      end
    end
    if (!rd) for (int i = 0; i < dnE; i++) begin
      k++;
      if (nackAt < 0 || k <= nackAt) begin
        expQ.push_back(dw[i*8 +: 8]); tagQ.push_back("R4");
      end
    end
    expRd = '0;
    for (int i = 0; i < dnE; i++) expRd[i*8 +: 8] = rdw[i*8 +: 8];
    starts = 0;
    stops = 0;
    @(negedge clk);
    readMode = rd; slaveAddr = a; cmdWord = cw; cmdCount = 3'(cn);
    dataWord = dw; dataCount = 3'(dn); prescale = 8'(pre);
    fork slaveRun(); join_none
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk(busy == 1'b1, "R9", "busy after start", {31'd0, busy}, 32'd1);
    chk(nack == 1'b0, "R7", "nack cleared by start", {31'd0, nack}, 32'd0);
    gotDone = 1'b0;
    for (t = 0; t < 20000; t++) begin
      if (poke && t == 40) begin
        startPulse = 1'b1; cmdWord = ~cw; dataWord = ~dw;
        readMode = ~rd; cmdCount = 3'd0;
      end
      if (poke && t == 41) startPulse = 1'b0;
      if (done) begin
        chk(busy == 1'b0, "R9", "busy low with done", {31'd0, busy}, 32'd0);
        gotDone = 1'b1;
        break;
      end
      @(negedge clk);
    end
    chk(gotDone, "R9", "done pulse seen", {31'd0, gotDone}, 32'd1);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle", {31'd0, done}, 32'd0);
    wait fork;
    chk(expQ.size() == 0, "R2", "bytes left in queue", expQ.size(), 32'd0);
    chk(nack == (nackAt >= 0), "R7", "nack flag", {31'd0, nack},
        {31'd0, (nackAt >= 0)});
    if (rd && nackAt < 0)
      chk(rdData == expRd, "R5", "read word", rdData, expRd);
    chk(lastPeriod == 4*TDIV*(pEff+1), "R1", "scl period", lastPeriod,
        4*TDIV*(pEff+1));
    chk(starts == 1 && stops == 1, "R8", "one START and one STOP",
        starts*16 + stops, 32'h11);
    chk(!sdaOe && !sclOe, "R8", "bus released", {30'd0, sdaOe, sclOe}, 32'd0);
    if (poke) begin
      bit seen;
      seen = 1'b0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (busy || done) seen = 1'b1;
      end
      chk(!seen, "R10", "start while busy ignored", {31'd0, seen}, 32'd0);
    end
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog act=%0d exp=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !nack, "R9", "reset status",
        {29'd0, busy, done, nack}, 32'd0);
    chk(!sdaOe && !sclOe, "R8", "reset bus idle", {30'd0, sdaOe, sclOe}, 32'd0);
    chk(rdData == 32'd0, "R5", "reset read word", rdData, 32'd0);

    // writes: R2 R3 R4 with several counts and prescales (R1)
    runTxn(1'b0, 7'h50, 32'h1234BEEF, 2, 32'hCAFE00A5, 2, 1, -1, 0, 1'b0);
    runTxn(1'b0, 7'h2B, 32'h0, 0, 32'h0, 0, 0, -1, 0, 1'b0);
    runTxn(1'b0, 7'h11, 32'h89ABCDEF, 4, 32'h01234567, 4, 3, -1, 0, 1'b0);
    // R3 count 6 acts as 4
    runTxn(1'b0, 7'h7F, 32'hF0E1D2C3, 6, 32'h0000005A, 1, 1, -1, 0, 1'b0);
    // reads: R5 R6
    runTxn(1'b1, 7'h48, 32'h0000A1B2, 2, 32'h0, 4, 2, -1, 32'hA55A3CC3, 1'b0);
    runTxn(1'b1, 7'h33, 32'h00000077, 1, 32'h0, 1, 1, -1, 32'h000000E7, 1'b0);
    runTxn(1'b1, 7'h05, 32'h0, 0, 32'h0, 3, 1, -1, 32'hFF817E42, 1'b0);
    // R7: refusal at the address byte, then sticky check
    runTxn(1'b0, 7'h6C, 32'h00003344, 2, 32'h00005566, 2, 1, 0, 0, 1'b0);
    repeat (30) @(negedge clk);
    chk(nack == 1'b1, "R7", "nack sticky while idle", {31'd0, nack}, 32'd1);
    // R7: refusal at the second command byte of a read
    runTxn(1'b1, 7'h1D, 32'h44332211, 4, 32'h0, 2, 1, 2, 32'h0000BEEF, 1'b0);
    // R10: start pulse and input changes while busy
    runTxn(1'b0, 7'h42, 32'h000000C4, 1, 32'h0000003B, 1, 1, -1, 0, 1'b1);
    runTxn(1'b0, 7'h0A, 32'h00000099, 1, 32'h0, 0, 1, -1, 0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule